// File: doc/BRIEF.md
# Two-Pass 8x8 Fixed-Point FFT (64 points)

This block computes a 64-point complex discrete Fourier transform, or its inverse, on fixed-point samples. The transform is split into an 8 by 8 grid. First, eight 8-point transforms run down the stride-8 columns of the input. Next, every intermediate value is rotated by a 64th root of unity. Finally, eight more 8-point transforms run along the other index. Each 8-point transform is a radix-2 decimation-in-frequency kernel with three butterfly stages. Every constant product is a hardwired shift-and-add network. The datapath has no general multiplier and no coefficient storage.

A frame of 64 samples is loaded over a valid/ready input stream. A transfer happens on any rising edge where both `in_valid` and `in_ready` are high. The source may hold off between samples for any number of cycles. `in_ready` is high only while a frame is being collected. After the 64th sample, the block computes for one cycle. It then presents bins 0 to 63 in natural order on a valid/ready output stream. When the sink holds `out_ready` low, the current bin and its last flag stay frozen until they are taken. No new input is accepted until the final bin has left.

The inverse mode reuses the forward datapath. The block negates the imaginary part of each input sample on entry and negates the imaginary part of each result on exit.

Top module: `fft64_2d`

## Requirements
- R1: While reset is held, `in_ready` is 1 and `out_valid` is 0.
- R2: Each sample is a two's-complement pair, with the real part in bits [31:16] and the imaginary part in bits [15:0]. `in_ready` and `out_valid` are never high together. `in_ready` stays low from the last input transfer until the last output transfer of that frame.
- R3: With the forward mode (`inv_mode` = 0), output bin k equals (1/64)·Σ x[n]·e^(−j2πnk/64), within 4 LSB in each of the real and imaginary parts.
- R4: With the inverse mode (`inv_mode` = 1), output bin k equals (1/64)·Σ x[n]·e^(+j2πnk/64), within 4 LSB in each part.
- R5: Bins leave in order 0, 1, …, 63, with the same field layout as the input. `out_last` is high with bin 63 and with no other bin.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values on the next cycle.
- R7: `out_valid` is low in the cycle after the transfer of input sample 63 and high in the cycle after that. In the cycle after the transfer of bin 63, `in_ready` is high and `out_valid` is low.
- R8: `inv_mode` is sampled only on the transfer of sample 0 of a frame. Changing it later in the same frame does not alter that frame's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inv_mode | input | 1 | 1 selects the inverse transform, sampled with sample 0 |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block is collecting a frame |
| in_data | input | 2*DW | Sample: real [2*DW-1:DW], imaginary [DW-1:0] |
| out_valid | output | 1 | Output bin present |
| out_ready | input | 1 | Sink accepts the bin |
| out_data | output | 2*DW | Bin: real [2*DW-1:DW], imaginary [DW-1:0] |
| out_last | output | 1 | Marks bin 63 |

## Verification
The bench builds the block with the default DW = 16. At that width, 16-bit inputs of up to ±16000 per part keep every rotated intermediate value inside range. This lets the accumulated rounding of six halving stages and two rotation levels be compared with a double-precision DFT at a tight 4 LSB limit. The stimulus covers impulses, a constant, tones in both directions (the inverse tone lands on the mirrored bin) and random frames. Random input gaps and random output stalls exercise the hold and latency rules. Frames that flip the mode input partway through show that only the first sample's mode counts.

// File: rtl/fft64_pkg.sv
package fft64_pkg;
  typedef enum logic [1:0] {ST_LOAD, ST_CALC, ST_SEND} fft_state_e;

  localparam int QF  = 14;     // fractional bits of every rotation constant
  localparam int RSQ = 11585;  // 1/sqrt(2) in Q14

  function automatic int clamp_w(int v, int w);
    int hi;
    int lo;
    hi = (1 <<< (w - 1)) - 1;
    lo = -hi - 1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int half_rnd(int v);
    return (v + 1) >>> 1;
  endfunction

  function automatic int qround(int p);
    return (p + (1 <<< (QF - 1))) >>> QF;
  endfunction

  // Constant product as a sum of shifted copies; k is always elaboration-constant.
  function automatic int kmul(int x, int k);
    int acc;
    int m;
    acc = 0;
    m = (k < 0) ? -k : k;
    for (int b = 0; b <= QF; b++)
      if (m[b]) acc += x <<< b;
    return (k < 0) ? -acc : acc;
  endfunction

  // cos(2*pi*m/64) in Q14 for the first quadrant, m = 0..16.
  function automatic int cos_q(int m);
    case (m)
      0: return 16384;   1: return 16305;   2: return 16069;   3: return 15679;
      4: return 15137;   5: return 14449;   6: return 13623;   7: return 12665;
      8: return 11585;   9: return 10394;  10: return 9102;   11: return 7723;
      12: return 6270;  13: return 4756;   14: return 3196;   15: return 1606;
      default: return 0;
    endcase
  endfunction

  function automatic int cos64(int e);
    int r;
    r = e % 64;
    if (r <= 16) return cos_q(r);
    if (r <= 32) return -cos_q(32 - r);
    if (r <= 48) return -cos_q(r - 32);
    return cos_q(64 - r);
  endfunction

  function automatic int sin64(int e);
    return cos64(e + 48);
  endfunction
endpackage

// File: rtl/fft8_kernel.sv
module fft8_kernel
  import fft64_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] xr [8],
  input  logic signed [DW-1:0] xi [8],
  output logic signed [DW-1:0] yr [8],
  output logic signed [DW-1:0] yi [8]
);
  // Multiply by W8^idx (idx 0..3) using the shared 1/sqrt(2) network.
  function automatic void rot8(input int r, input int i, input int idx,
                               output int orr, output int oi);
    case (idx)
      1: begin orr = qround(kmul(r + i, RSQ));    oi = qround(kmul(i - r, RSQ));    end
      2: begin orr = i;                            oi = -r;                          end
      3: begin orr = qround(kmul(i - r, RSQ));    oi = qround(kmul(-(r + i), RSQ)); end
      default: begin orr = r; oi = i; end
    endcase
    orr = clamp_w(orr, DW);
    oi  = clamp_w(oi, DW);
  endfunction

  always_comb begin
    int ar [8];
    int ai [8];
    int br [8];
    int bi [8];
    int cr [8];
    int ci [8];
    int dr;
    int di;
    int rv;
    // stage 1: span 4
    for (int i = 0; i < 4; i++) begin
      ar[i] = half_rnd(int'(xr[i]) + int'(xr[i+4]));
      ai[i] = half_rnd(int'(xi[i]) + int'(xi[i+4]));
      dr    = half_rnd(int'(xr[i]) - int'(xr[i+4]));
      di    = half_rnd(int'(xi[i]) - int'(xi[i+4]));
      rot8(dr, di, i, ar[i+4], ai[i+4]);
    end
    // stage 2: span 2 inside each half
    for (int h = 0; h < 8; h += 4) begin
      for (int j = 0; j < 2; j++) begin
        br[h+j] = half_rnd(ar[h+j] + ar[h+j+2]);
        bi[h+j] = half_rnd(ai[h+j] + ai[h+j+2]);
        dr      = half_rnd(ar[h+j] - ar[h+j+2]);
        di      = half_rnd(ai[h+j] - ai[h+j+2]);
        rot8(dr, di, 2 * j, br[h+j+2], bi[h+j+2]);
      end
    end
    // stage 3: span 1
    for (int p = 0; p < 8; p += 2) begin
      cr[p]   = half_rnd(br[p] + br[p+1]);
      ci[p]   = half_rnd(bi[p] + bi[p+1]);
      cr[p+1] = half_rnd(br[p] - br[p+1]);
      ci[p+1] = half_rnd(bi[p] - bi[p+1]);
    end
    // undo the bit-reversed order
    for (int k = 0; k < 8; k++) begin
      rv = ((k & 1) << 2) | (k & 2) | ((k >> 2) & 1);
      yr[k] = DW'(cr[rv]);
      yi[k] = DW'(ci[rv]);
    end
  end
endmodule

// File: rtl/fft_twiddle.sv
module fft_twiddle
  import fft64_pkg::*;
#(
  parameter int DW  = 16,
  parameter int EXP = 0
) (
  input  logic signed [DW-1:0] ar,
  input  logic signed [DW-1:0] ai,
  output logic signed [DW-1:0] br,
  output logic signed [DW-1:0] bi
);
  localparam int CK = cos64(EXP);
  localparam int SK = sin64(EXP);

  // (a + jb) * (C - jS)
  always_comb begin
    int pr;
    int pi;
    pr = qround(kmul(int'(ar), CK) + kmul(int'(ai), SK));
    pi = qround(kmul(int'(ai), CK) - kmul(int'(ar), SK));
    br = DW'(clamp_w(pr, DW));
    bi = DW'(clamp_w(pi, DW));
  end
endmodule

// File: rtl/fft64_2d.sv
module fft64_2d
  import fft64_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2*DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2*DW-1:0] out_data,
  output logic          out_last
);
  localparam int RAD = 8;
  localparam int NPT = RAD * RAD;
  localparam int IW  = $clog2(NPT);
  localparam logic [IW-1:0] LASTIX = IW'(NPT - 1);

  fft_state_e state;
  logic [IW-1:0] cnt;
  logic mode_q, take, give, cur_inv;
  logic signed [DW-1:0] conj_in_i, out_im;

  logic signed [DW-1:0] in_r  [NPT];
  logic signed [DW-1:0] in_i  [NPT];
  logic signed [DW-1:0] res_r [NPT];
  logic signed [DW-1:0] res_i [NPT];

  logic signed [DW-1:0] col_r [RAD][RAD];
  logic signed [DW-1:0] col_i [RAD][RAD];
  logic signed [DW-1:0] p1_r  [RAD][RAD];
  logic signed [DW-1:0] p1_i  [RAD][RAD];
  logic signed [DW-1:0] tw_r  [RAD][RAD];
  logic signed [DW-1:0] tw_i  [RAD][RAD];
  logic signed [DW-1:0] row_r [RAD][RAD];
  logic signed [DW-1:0] row_i [RAD][RAD];
  logic signed [DW-1:0] p2_r  [RAD][RAD];
  logic signed [DW-1:0] p2_i  [RAD][RAD];

  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_SEND);
  assign take      = in_valid && in_ready;
  assign give      = out_valid && out_ready;
  assign cur_inv   = (cnt == '0) ? inv_mode : mode_q;

  always_comb begin
    conj_in_i = $signed(in_data[DW-1:0]);
    if (cur_inv) conj_in_i = DW'(clamp_w(-int'($signed(in_data[DW-1:0])), DW));
  end

  // pass 1: one kernel per column n1, fed with x[n1 + 8*n2]
  for (genvar n1 = 0; n1 < RAD; n1++) begin : g_pass1
    for (genvar n2 = 0; n2 < RAD; n2++) begin : g_col
      assign col_r[n1][n2] = in_r[n1 + RAD*n2];
      assign col_i[n1][n2] = in_i[n1 + RAD*n2];
    end
    fft8_kernel #(.DW(DW)) u_k1 (
      .xr(col_r[n1]), .xi(col_i[n1]), .yr(p1_r[n1]), .yi(p1_i[n1])
    );
    // twiddle W64^(n1*k1), each a fixed shift-add network
    for (genvar k1 = 0; k1 < RAD; k1++) begin : g_tw
      fft_twiddle #(.DW(DW), .EXP(n1 * k1)) u_tw (
        .ar(p1_r[n1][k1]), .ai(p1_i[n1][k1]), .br(tw_r[n1][k1]), .bi(tw_i[n1][k1])
      );
      assign row_r[k1][n1] = tw_r[n1][k1];
      assign row_i[k1][n1] = tw_i[n1][k1];
    end
  end

  // pass 2: one kernel per k1 across n1; output bin k1 + 8*k2
  for (genvar k1 = 0; k1 < RAD; k1++) begin : g_pass2
    fft8_kernel #(.DW(DW)) u_k2 (
      .xr(row_r[k1]), .xi(row_i[k1]), .yr(p2_r[k1]), .yi(p2_i[k1])
    );
  end

  always_ff @(posedge clk) begin
    if (take) begin
      in_r[cnt] <= $signed(in_data[2*DW-1:DW]);
      in_i[cnt] <= conj_in_i;
    end
    if (state == ST_CALC) begin
      for (int k1 = 0; k1 < RAD; k1++)
        for (int k2 = 0; k2 < RAD; k2++) begin
          res_r[k1 + RAD*k2] <= p2_r[k1][k2];
          res_i[k1 + RAD*k2] <= p2_i[k1][k2];
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_LOAD;
      cnt    <= '0;
      mode_q <= 1'b0;
    end else begin
      case (state)
        ST_LOAD: if (take) begin
          if (cnt == '0) mode_q <= inv_mode;
          cnt <= cnt + 1'b1;
          if (cnt == LASTIX) state <= ST_CALC;
        end
        ST_CALC: state <= ST_SEND;
        ST_SEND: if (give) begin
          cnt <= cnt + 1'b1;
          if (cnt == LASTIX) state <= ST_LOAD;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  always_comb begin
    out_im = res_i[cnt];
    if (mode_q) out_im = DW'(clamp_w(-int'(res_i[cnt]), DW));
  end
  assign out_data = {res_r[cnt], out_im};
  assign out_last = out_valid && (cnt == LASTIX);

  AST_READY_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(in_ready && out_valid)); // R2
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) out_last |-> out_valid); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R6
  AST_CALC_GAP: assert property (@(posedge clk) disable iff (!rst_n) (take && cnt == LASTIX) |=> (!in_ready && !out_valid)); // R7
  AST_RESUME_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (give && out_last) |=> (in_ready && !out_valid)); // R7
endmodule

// File: tb/fft64_2d_bench.sv
`timescale 1ns/1ps
module fft64_2d_bench;
  localparam int DW  = 16;
  localparam int NPT = 64;
  localparam int TOL = 4;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inv_mode = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [2*DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic [2*DW-1:0] out_data;

  fft64_2d #(.DW(DW)) u_fft64_2d (
    .clk(clk), .rst_n(rst_n), .inv_mode(inv_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  always #4 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  int exp_re[$];
  int exp_im[$];
  string exp_tag[$];
  int xr[NPT];
  int xi[NPT];
  bit stall_en = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int rnd(real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int absi(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic build_ref(bit inv, string tag);
    real sgn;
    sgn = inv ? -1.0 : 1.0;
    for (int k = 0; k < NPT; k++) begin
      real sr;
      real si;
      sr = 0.0;
      si = 0.0;
      for (int n = 0; n < NPT; n++) begin
        real th;
        th = 2.0 * PI * real'(n * k) / 64.0;
        sr += real'(xr[n]) * $cos(th) + sgn * real'(xi[n]) * $sin(th);
        si += real'(xi[n]) * $cos(th) - sgn * real'(xr[n]) * $sin(th);
      end
      exp_re.push_back(rnd(sr / 64.0));
      exp_im.push_back(rnd(si / 64.0));
      exp_tag.push_back(tag);
    end
  endtask

  task automatic send_frame(bit inv, bit toggle, bit gaps);
    string tag;
    tag = toggle ? "R8" : (inv ? "R4" : "R3");
    build_ref(inv, tag);
    for (int n = 0; n < NPT; n++) begin
      @(negedge clk);
      if (gaps) begin
        while ($urandom_range(0, 2) == 0) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
      end
      in_valid = 1'b1;
      in_data  = {xr[n][DW-1:0], xi[n][DW-1:0]};
      inv_mode = (n == 0 || !toggle) ? inv : ~inv;
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(!out_valid && !in_ready, "R7", "busy cycle after last input (valid,ready)",
        {out_valid, in_ready}, 0);
    @(negedge clk);
    #1;
    chk(out_valid, "R7", "out_valid second cycle after last input", out_valid, 1);
  endtask

  // output monitor / reference comparison on every clock
  initial begin
    int bin;
    bit prev_stall;
    bit resume_chk;
    logic [2*DW-1:0] prev_data;
    logic prev_last;
    bin = 0;
    prev_stall = 0;
    resume_chk = 0;
    prev_data = '0;
    prev_last = 0;
    forever begin
      @(negedge clk);
      out_ready = stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
      #1;
      if (rst_n) begin
        if (prev_stall)
          chk(out_valid && out_data == prev_data && out_last == prev_last,
              "R6", "held bin during stall", int'(out_data), int'(prev_data));
        if (resume_chk)
          chk(in_ready && !out_valid, "R7", "in_ready after bin 63 (ready,valid)",
              {in_ready, out_valid}, 2);
        resume_chk = 0;
        if (out_valid) begin
          chk(!in_ready, "R2", "in_ready low while output pending", in_ready, 0);
          if (out_ready) begin
            if (exp_re.size() == 0) begin
              chk(0, "R5", "unexpected output bin", bin, -1);
            end else begin
              int er;
              int ei;
              int ar;
              int ai;
              string tg;
              er = exp_re.pop_front();
              ei = exp_im.pop_front();
              tg = exp_tag.pop_front();
              ar = int'($signed(out_data[2*DW-1:DW]));
              ai = int'($signed(out_data[DW-1:0]));
              chk(absi(ar - er) <= TOL, tg, $sformatf("bin %0d real", bin), ar, er);
              chk(absi(ai - ei) <= TOL, tg, $sformatf("bin %0d imag", bin), ai, ei);
              chk(out_last == (bin == NPT - 1), "R5", $sformatf("last flag at bin %0d", bin),
                  out_last, (bin == NPT - 1));
              if (bin == NPT - 1) resume_chk = 1;
              bin = (bin + 1) % NPT;
            end
          end
        end
      end
      prev_stall = rst_n && out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: impulse at n=0 spreads evenly over all bins
    for (int n = 0; n < NPT; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[0] = 16000;
    send_frame(0, 0, 0);

    // R3/R6: shifted complex impulse with output stalls
    stall_en = 1;
    for (int n = 0; n < NPT; n++) begin xr[n] = 0; xi[n] = 0; end
    xr[9] = 8000; xi[9] = -12000;
    send_frame(0, 0, 1);

    // R3: tone on bin 3
    for (int n = 0; n < NPT; n++) begin
      xr[n] = rnd(12000.0 * $cos(2.0 * PI * 3.0 * n / 64.0));
      xi[n] = rnd(12000.0 * $sin(2.0 * PI * 3.0 * n / 64.0));
    end
    send_frame(0, 0, 0);

    // R4/R8: same tone inverse, mode flipped after sample 0 (peak moves to bin 61)
    send_frame(1, 1, 1);

    // R3: constant input lands on bin 0 only
    for (int n = 0; n < NPT; n++) begin xr[n] = 8000; xi[n] = -5000; end
    stall_en = 0;
    send_frame(0, 0, 0);

    // R8: random forward, mode flipped after sample 0
    stall_en = 1;
    for (int n = 0; n < NPT; n++) begin
      xr[n] = int'($urandom_range(0, 30000)) - 15000;
      xi[n] = int'($urandom_range(0, 30000)) - 15000;
    end
    send_frame(0, 1, 1);

    // R4: random inverse
    for (int n = 0; n < NPT; n++) begin
      xr[n] = int'($urandom_range(0, 30000)) - 15000;
      xi[n] = int'($urandom_range(0, 30000)) - 15000;
    end
    send_frame(1, 0, 0);

    // drain
    while (exp_re.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule